// File: doc/BRIEF.md
# Two-Level Block Carry-Skip Adder

This block is a purely combinational binary adder for two operands and a carry-in, giving a sum of the same width and a carry-out. The operand bits are cut into ripple-carry segments. Inside a segment the carry passes bit by bit through full-adder cells. Each segment ANDs its per-bit propagate terms into one group propagate. When that group propagate is high, a 2:1 selector sends the segment's incoming carry straight on to the next segment and skips the ripple chain.

A second skip level collects a fixed number of adjacent segments (four by default) into a super-segment. The AND of their group propagates drives a second selector. When it is high, the carry entering the super-segment leaves it at once.

The segment sizes are a parameter list. The default is eight 4-bit segments, which gives 32 bits in two 16-bit super-segments. A segment size of 4 is the value near sqrt(32/2) that minimises delay. A non-uniform list may be given instead, with short segments at both ends and longer ones in the middle, as long as its entries add up to the width.

Top module: `csk_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals opnd_a + opnd_b + carry_in taken as an unsigned (WIDTH+1)-bit value.
- R2: Within a segment, each bit uses propagate p = a XOR b and generate g = a AND b. Its sum bit is p XOR incoming carry, and its carry is g OR (p AND incoming carry).
- R3: When every bit of the word propagates (opnd_a = ~opnd_b), the sum is all ones and carry_out is 0 for carry_in = 0. The sum is all zeros and carry_out is 1 for carry_in = 1.
- R4: When all bits of a super-segment propagate, the carry entering it appears unchanged as the carry leaving it. This holds both for a carry produced in the segment below and for a carry that is absent.
- R5: The default configuration is WIDTH = 32 with eight 4-bit segments grouped four to a super-segment.
- R6: A non-uniform segment list (for example 2,3,5,6,6,5,3,2) gives the same results as R1.
- R7: The block holds no state. Its outputs follow the present inputs with no clock.
- R8: carry_out is the carry leaving the most significant segment. For example, all-ones plus 1 gives sum 0 and carry_out 1.
- R9: carry_in alone is added at bit 0. For example, 0 + 0 + 1 gives sum 1 and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First addend |
| opnd_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Every result is due zero cycles after its stimulus, because the adder is combinational. The driver applies operands just after a rising edge of the bench clock and queues the expected value. The monitor takes the result off the queue and compares it on the following falling edge, half a period later, so the inputs have long settled. A default-partition instance and a non-uniform instance receive the same stimulus. Directed all-propagate words at the word and super-segment level push carries through every skip selector, and a long random run covers the general case.

// File: rtl/csk_pkg.sv
package csk_pkg;

    localparam int unsigned MAX_SEG = 16;

    typedef int unsigned seg_list_t [MAX_SEG];

    localparam seg_list_t SEG_UNIFORM4 = '{default: 4};

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    function automatic pg_t make_pg(input logic a, input logic b);
        pg_t r;
        r.p = a ^ b;
        r.g = a & b;
        return r;
    endfunction

    // bit offset of segment idx (sum of sizes of all segments below it)
    function automatic int unsigned seg_lo(input seg_list_t sz, input int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int k = 0; k < int'(MAX_SEG); k++) begin
            if (k < int'(idx)) acc += sz[k];
        end
        return acc;
    endfunction

endpackage

// File: rtl/csk_segment.sv
module csk_segment #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         gp,
    output logic         cout
);
    csk_pkg::pg_t [W-1:0] pg;
    logic [W:0]           c;

    always_comb begin
        c[0] = cin;
        gp   = 1'b1;
        for (int i = 0; i < int'(W); i++) begin
            pg[i]    = csk_pkg::make_pg(a[i], b[i]);
            c[i+1]   = pg[i].g | (pg[i].p & c[i]);
            sum[i]   = pg[i].p ^ c[i];
            gp       = gp & pg[i].p;
        end
    end

    assign cout = gp ? cin : c[W];

    logic [W:0] seg_ref;
    always_comb begin
        seg_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        // R2
        seg_ripple_chk : assert ({c[W], sum} == seg_ref)
            else $error("segment ripple result mismatch");
        // R3
        seg_skip_chk : assert (!gp || (c[W] == cin))
            else $error("skipped segment ripple carry differs from incoming carry");
    end

endmodule

// File: rtl/csk_super.sv
module csk_super #(
    parameter csk_pkg::seg_list_t SZ    = csk_pkg::SEG_UNIFORM4,
    parameter int unsigned        FIRST = 0,
    parameter int unsigned        GRP   = 4,
    parameter int unsigned        W     = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned BASE = csk_pkg::seg_lo(SZ, FIRST);

    logic [GRP:0]   bc;
    logic [GRP-1:0] gps;
    logic           sp;

    assign bc[0] = cin;

    for (genvar j = 0; j < int'(GRP); j++) begin : g_seg
        localparam int unsigned LO = csk_pkg::seg_lo(SZ, FIRST + j) - BASE;
        localparam int unsigned SW = SZ[FIRST + j];
        csk_segment #(.W(SW)) u_seg (
            .a    (a[LO +: SW]),
            .b    (b[LO +: SW]),
            .cin  (bc[j]),
            .sum  (sum[LO +: SW]),
            .gp   (gps[j]),
            .cout (bc[j+1])
        );
    end

    assign sp   = &gps;
    assign cout = sp ? cin : bc[GRP];

    logic [W:0] sup_ref;
    always_comb begin
        sup_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        // R1
        sup_sum_chk : assert ({cout, sum} == sup_ref)
            else $error("super-segment result mismatch");
        // R4
        sup_skip_chk : assert (!sp || (bc[GRP] == cin))
            else $error("first-level carry disagrees with super skip");
    end

endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
    parameter int unsigned        WIDTH = 32,
    parameter int unsigned        NSEG  = 8,
    parameter int unsigned        GRP   = 4,
    parameter csk_pkg::seg_list_t SZ    = csk_pkg::SEG_UNIFORM4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int unsigned NSUP = NSEG / GRP;

    if (csk_pkg::seg_lo(SZ, NSEG) != WIDTH) begin : g_bad_sizes
        $error("segment sizes do not add up to WIDTH");
    end
    if ((NSEG % GRP) != 0 || NSEG > csk_pkg::MAX_SEG) begin : g_bad_group
        $error("segment count must be a multiple of GRP and at most MAX_SEG");
    end

    logic [NSUP:0] sc;
    assign sc[0] = carry_in;

    for (genvar s = 0; s < int'(NSUP); s++) begin : g_sup
        localparam int unsigned LO = csk_pkg::seg_lo(SZ, s * GRP);
        localparam int unsigned SW = csk_pkg::seg_lo(SZ, (s + 1) * GRP) - LO;
        csk_super #(.SZ(SZ), .FIRST(s * GRP), .GRP(GRP), .W(SW)) u_sup (
            .a    (opnd_a[LO +: SW]),
            .b    (opnd_b[LO +: SW]),
            .cin  (sc[s]),
            .sum  (sum[LO +: SW]),
            .cout (sc[s+1])
        );
    end

    // R8: the carry out of the top super-segment leaves the adder
    assign carry_out = sc[NSUP];

    logic [WIDTH:0] top_ref;
    always_comb begin
        top_ref = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
        // R1
        add_result_chk : assert ({carry_out, sum} == top_ref)
            else $error("adder result mismatch");
    end

endmodule

// File: tb/csk_adder_bench.sv
module csk_adder_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 32;
    localparam csk_pkg::seg_list_t VAR_SZ =
        '{2, 3, 5, 6, 6, 5, 3, 2, 0, 0, 0, 0, 0, 0, 0, 0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic         ci = 1'b0;
    logic [W-1:0] s_fix, s_var;
    logic         co_fix, co_var;

    always #(CLK_PERIOD/2) clk = ~clk;

    // R5: default parameters
    csk_adder u_csk_adder (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum(s_fix), .carry_out(co_fix)
    );

    // R6: non-uniform partition
    csk_adder #(.WIDTH(W), .NSEG(8), .GRP(4), .SZ(VAR_SZ)) u_csk_adder_var (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum(s_var), .carry_out(co_var)
    );

    typedef struct {
        logic [W:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad   = 0;
    bit    drv_done = 1'b0;

    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string req);
        item_t it;
        @(posedge clk);
        #1;
        a  = x;
        b  = y;
        ci = c;
        it.exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        it.req = req;
        q.push_back(it);
    endtask

    // monitor: results due in the same cycle, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if ({co_fix, s_fix} !== it.exp) begin
                bad++;
                $display("FAIL %s fixed: got %h expected %h", it.req, {co_fix, s_fix}, it.exp);
            end
            total++;
            if ({co_var, s_var} !== it.exp) begin
                bad++;
                $display("FAIL %s R6 variable: got %h expected %h", it.req, {co_var, s_var}, it.exp);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R7: idle inputs give zero result without any clocking of the adder
        drive(32'h0, 32'h0, 1'b0, "R7 idle");
        drive(32'h0, 32'h0, 1'b1, "R9 carry-in only");
        drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R8 wrap");
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 all ones");
        drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0, "R3 propagate cin0");
        drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, "R3 propagate cin1");
        drive(32'h0000_0000, 32'hFFFF_FFFF, 1'b1, "R3 zero plus ones");
        // R4: upper super-segment all-propagate, carry made in the lower one
        drive(32'h1234_8000, 32'hEDCB_8000, 1'b0, "R4 carry generated");
        drive(32'h1234_0000, 32'hEDCB_0000, 1'b0, "R4 no carry");
        drive(32'h0000_FFFF, 32'h0000_0000, 1'b1, "R4 lower skip");
        drive(32'h000F_0000, 32'h0000_FFFF, 1'b1, "R2 segment ripple");
        drive(32'h1111_1111, 32'h2222_2222, 1'b0, "R2 no carries");
        for (int i = 0; i < 2000; i++) begin
            drive($urandom, $urandom, 1'($urandom), "R1 random");
        end
        @(posedge clk);
        drv_done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!(drv_done && q.size() == 0) && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
        if (cyc >= 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: got timeout expected completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule